// File: doc/BRIEF.md
# Display Bias Rail Sequencer with Fault Handling

This block runs the positive and negative display bias rails through their life cycle. A decoded enable and a decoded discharge option arrive from the single-wire control decoder. Digitised comparator flags arrive from the analog side: undervoltage, over-temperature, thermal-cleared, output short, positive-rail-good and negative-rail-good. The block brings the positive regulator up first and the negative one second. It holds both rails in regulation and shuts them down on power-off or on a fault. Before the outputs float, it can run a timed discharge.

There are two recovery policies. A qualified output short, or a rail that fails to come up in its start window, latches the block off. Only an off-then-on cycle of the enable releases it. Over-temperature and undervoltage recover on their own. Thermal recovery waits for the separate cleared flag, which supplies the hysteresis. Undervoltage recovery follows the undervoltage flag. Every timer limit is a cycle-count parameter, so the block can be retargeted to any clock.

Top module: `bias_seq_ctrl`

## Requirements
- R1: During and after reset, with the enable low, the state output is OFF (bit 0). All regulator and discharge enables are low, out_hiz is high, and fault_cause reads 0.
- R2: On enable, the block enters START_POS with only the positive regulator on. It stays there exactly POS_UP_CYC cycles when pos_good is already high. It then enters START_NEG with both regulators on, and it reaches REGULATE after neg_good rises.
- R3: If the positive rail is not good within POS_TMO_CYC cycles of entering START_POS, the block shuts down, records a short, and latches off. The same applies if the negative rail is not good within NEG_TMO_CYC cycles of entering START_NEG.
- R4: During startup or regulation, a short flag held for SCP_CYC consecutive cycles shuts the rails down. Shorter pulses have no effect, and a gap of one low cycle restarts the count.
- R5: After a latched shutdown, the block stays in LATCHED (bit 6) while the enable is high. It leaves only through a low enable (to HIZ) followed by a new high enable.
- R6: Over-temperature shuts the rails down to HIZ. The block restarts on its own only after the thermal-cleared flag asserts while the over-temperature flag is low, with the enable still high.
- R7: Undervoltage shuts the rails down to HIZ. The block stays down while the flag is high and restarts on its own once it clears.
- R8: With the discharge option set at shutdown, dis_en is high for exactly DIS_CYC cycles with both regulators off. A fault arriving during that window neither extends the window nor alters fault_cause.
- R9: With the discharge option clear, a shutdown goes directly to HIZ (bit 5) or LATCHED with no discharge cycle.
- R10: A low enable during startup or regulation is a power-off. It shuts the rails down and leaves fault_cause unchanged.
- R11: fault_cause encodes none=0, short=1, thermal=2, undervoltage=3. Simultaneous faults resolve as undervoltage over thermal over short. The field clears to 0 on each entry to REGULATE.
- R12: state_oh is one-hot with bit order OFF=0, START_POS=1, START_NEG=2, REGULATE=3, DISCHARGE=4, HIZ=5, LATCHED=6.
- R13: The negative regulator enable is never high while the positive regulator enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_en | input | 1 | Decoded bias enable (synchronous) |
| dis_opt | input | 1 | Decoded discharge option (synchronous) |
| uv_flag | input | 1 | Undervoltage comparator flag (asynchronous) |
| ot_flag | input | 1 | Over-temperature flag (asynchronous) |
| ot_clr_flag | input | 1 | Temperature-cleared flag (asynchronous) |
| short_flag | input | 1 | Output-short comparator flag (asynchronous) |
| pos_good | input | 1 | Positive rail in regulation (asynchronous) |
| neg_good | input | 1 | Negative rail in regulation (asynchronous) |
| pos_reg_en | output | 1 | Positive regulator enable |
| neg_reg_en | output | 1 | Negative regulator enable |
| dis_en | output | 1 | Discharge switches closed on both rails |
| out_hiz | output | 1 | Outputs floating (no regulator, no discharge) |
| state_oh | output | 7 | One-hot state |
| fault_cause | output | 2 | Last shutdown fault cause |

## Verification
The state is exposed one-hot, so a wrong next-state decision appears on state_oh at the first clock edge after it is made. For a flag input, that is at most the synchroniser depth plus one cycle after the flag changes. A timer that is off by one shows as a START_POS, START_NEG or discharge dwell one cycle too long or too short. The bench counts those dwells exactly. A wrong latch or recovery policy appears as a block stuck in HIZ or LATCHED, or one that restarts early. A wrong cause priority shows on fault_cause in the same cycle the shutdown state appears.

// File: rtl/bias_seq_pkg.sv
package bias_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF       = 3'd0,
      ST_START_POS = 3'd1,
      ST_START_NEG = 3'd2,
      ST_REGULATE  = 3'd3,
      ST_DISCHARGE = 3'd4,
      ST_HIZ       = 3'd5,
      ST_LATCHED   = 3'd6
   } seq_state_t;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_SHORT   = 2'd1,
      CAUSE_THERMAL = 2'd2,
      CAUSE_UV      = 2'd3
   } fault_cause_t;

   localparam int NUM_STATES = 7;

endpackage

// File: rtl/bias_sync.sv
module bias_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/bias_fault_qual.sv
module bias_fault_qual #(
   parameter int SCP_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual_en,
   input  logic short_s,
   input  logic ot_s,
   input  logic ot_clr_s,
   output logic short_trip,
   output logic ot_hold
);

   localparam int SCP_W = $clog2(SCP_CYC + 1);
   localparam logic [SCP_W-1:0] SCP_LAST = SCP_W'(SCP_CYC - 1);

   logic [SCP_W-1:0] scp_cnt;

   // consecutive-cycle qualifier: any low cycle or inactive state restarts it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scp_cnt <= '0;
      end else if (!qual_en || !short_s) begin
         scp_cnt <= '0;
      end else if (scp_cnt != SCP_LAST) begin
         scp_cnt <= scp_cnt + 1'b1;
      end
   end

   assign short_trip = qual_en && short_s && (scp_cnt == SCP_LAST);

   // thermal hold: set by the hot flag, released only by the cleared flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ot_hold <= 1'b0;
      end else if (ot_s) begin
         ot_hold <= 1'b1;
      end else if (ot_clr_s) begin
         ot_hold <= 1'b0;
      end
   end

endmodule

// File: rtl/bias_seq_fsm.sv
module bias_seq_fsm
   import bias_seq_pkg::*;
#(
   parameter int POS_UP_CYC  = 1600,
   parameter int POS_TMO_CYC = 3000,
   parameter int NEG_TMO_CYC = 2000,
   parameter int DIS_CYC     = 20000
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rail_en,
   input  logic         dis_opt,
   input  logic         uv_s,
   input  logic         ot_hold,
   input  logic         short_trip,
   input  logic         pos_good_s,
   input  logic         neg_good_s,
   output seq_state_t   state,
   output fault_cause_t cause,
   output logic         qual_en
);

   localparam int MAX_A   = (POS_TMO_CYC > NEG_TMO_CYC) ? POS_TMO_CYC : NEG_TMO_CYC;
   localparam int TMR_MAX = (MAX_A > DIS_CYC) ? MAX_A : DIS_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TMR_MAX);
   localparam logic [TMR_W-1:0] POS_UP_L = TMR_W'(POS_UP_CYC - 1);
   localparam logic [TMR_W-1:0] POS_TO_L = TMR_W'(POS_TMO_CYC - 1);
   localparam logic [TMR_W-1:0] NEG_TO_L = TMR_W'(NEG_TMO_CYC - 1);
   localparam logic [TMR_W-1:0] DIS_L    = TMR_W'(DIS_CYC - 1);

   seq_state_t   state_nxt;
   fault_cause_t cause_nxt, new_cause;
   logic         latch_q, latch_nxt;
   logic [TMR_W-1:0] tmr;
   logic         pos_adv, tmo, fault_hit;

   assign qual_en  = (state == ST_START_POS) || (state == ST_START_NEG) ||
                     (state == ST_REGULATE);
   assign pos_adv  = pos_good_s && (tmr >= POS_UP_L);
   assign tmo      = ((state == ST_START_POS) && !pos_adv && (tmr == POS_TO_L)) ||
                     ((state == ST_START_NEG) && !neg_good_s && (tmr == NEG_TO_L));
   assign fault_hit = qual_en && (uv_s || ot_hold || short_trip || tmo);
   assign new_cause = uv_s ? CAUSE_UV : (ot_hold ? CAUSE_THERMAL : CAUSE_SHORT);

   always_comb begin
      state_nxt = state;
      cause_nxt = cause;
      latch_nxt = latch_q;
      case (state)
         ST_OFF, ST_HIZ:
            if (rail_en && !uv_s && !ot_hold) state_nxt = ST_START_POS;
         ST_START_POS:
            if (pos_adv) state_nxt = ST_START_NEG;
         ST_START_NEG:
            if (neg_good_s) state_nxt = ST_REGULATE;
         ST_REGULATE: ;
         ST_DISCHARGE:
            if (tmr == DIS_L) state_nxt = latch_q ? ST_LATCHED : ST_HIZ;
         ST_LATCHED:
            if (!rail_en) state_nxt = ST_HIZ;
         default:
            state_nxt = ST_OFF;
      endcase
      if (qual_en && (fault_hit || !rail_en)) begin
         if (fault_hit) begin
            cause_nxt = new_cause;
            latch_nxt = (new_cause == CAUSE_SHORT);
         end else begin
            latch_nxt = 1'b0;
         end
         if (dis_opt)        state_nxt = ST_DISCHARGE;
         else if (latch_nxt) state_nxt = ST_LATCHED;
         else                state_nxt = ST_HIZ;
      end
      if ((state_nxt == ST_REGULATE) && (state != ST_REGULATE)) cause_nxt = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_OFF;
         cause   <= CAUSE_NONE;
         latch_q <= 1'b0;
         tmr     <= '0;
      end else begin
         state   <= state_nxt;
         cause   <= cause_nxt;
         latch_q <= latch_nxt;
         if (state_nxt != state)  tmr <= '0;
         else if (tmr != TMR_LAST) tmr <= tmr + 1'b1;
      end
   end

endmodule

// File: rtl/bias_seq_ctrl.sv
module bias_seq_ctrl
   import bias_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SCP_CYC     = 1000,
   parameter int POS_UP_CYC  = 1600,
   parameter int POS_TMO_CYC = 3000,
   parameter int NEG_TMO_CYC = 2000,
   parameter int DIS_CYC     = 20000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rail_en,
   input  logic                  dis_opt,
   input  logic                  uv_flag,
   input  logic                  ot_flag,
   input  logic                  ot_clr_flag,
   input  logic                  short_flag,
   input  logic                  pos_good,
   input  logic                  neg_good,
   output logic                  pos_reg_en,
   output logic                  neg_reg_en,
   output logic                  dis_en,
   output logic                  out_hiz,
   output logic [NUM_STATES-1:0] state_oh,
   output logic [1:0]            fault_cause
);

   localparam int NFLAG = 6;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SCP_CYC < 1 || DIS_CYC < 1 || POS_UP_CYC < 1) begin : g_bad_cnt
      $error("cycle counts must be at least 1");
   end
   if (POS_UP_CYC >= POS_TMO_CYC) begin : g_bad_pos
      $error("POS_UP_CYC must be below POS_TMO_CYC");
   end
   if (NEG_TMO_CYC < 1) begin : g_bad_neg
      $error("NEG_TMO_CYC must be at least 1");
   end

   logic [NFLAG-1:0] flag_raw, flag_s;
   logic             short_trip, ot_hold, qual_en;
   seq_state_t       state;
   fault_cause_t     cause;

   assign flag_raw = {neg_good, pos_good, short_flag, ot_clr_flag, ot_flag, uv_flag};

   bias_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(flag_raw), .q(flag_s)
   );

   bias_fault_qual #(.SCP_CYC(SCP_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .qual_en(qual_en),
      .short_s(flag_s[3]), .ot_s(flag_s[1]), .ot_clr_s(flag_s[2]),
      .short_trip(short_trip), .ot_hold(ot_hold)
   );

   bias_seq_fsm #(
      .POS_UP_CYC(POS_UP_CYC), .POS_TMO_CYC(POS_TMO_CYC),
      .NEG_TMO_CYC(NEG_TMO_CYC), .DIS_CYC(DIS_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .dis_opt(dis_opt),
      .uv_s(flag_s[0]), .ot_hold(ot_hold), .short_trip(short_trip),
      .pos_good_s(flag_s[4]), .neg_good_s(flag_s[5]),
      .state(state), .cause(cause), .qual_en(qual_en)
   );

   always_comb begin
      state_oh = '0;
      state_oh[int'(state)] = 1'b1;
   end

   assign pos_reg_en  = state_oh[ST_START_POS] | state_oh[ST_START_NEG] | state_oh[ST_REGULATE];
   assign neg_reg_en  = state_oh[ST_START_NEG] | state_oh[ST_REGULATE];
   assign dis_en      = state_oh[ST_DISCHARGE];
   assign out_hiz     = state_oh[ST_OFF] | state_oh[ST_HIZ] | state_oh[ST_LATCHED];
   assign fault_cause = cause;

endmodule

// File: rtl/bias_seq_chk.sv
module bias_seq_chk #(
   parameter int DIS_CYC = 20000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       rail_en,
   input logic       pos_reg_en,
   input logic       neg_reg_en,
   input logic       dis_en,
   input logic       out_hiz,
   input logic [6:0] state_oh,
   input logic [1:0] fault_cause
);

   localparam int RUN_W = $clog2(DIS_CYC + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DIS_CYC + 1);
   logic [RUN_W-1:0] dis_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    dis_run <= '0;
      else if (!dis_en)              dis_run <= '0;
      else if (dis_run != RUN_MAX)   dis_run <= dis_run + 1'b1;
   end

   a_r12_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh) == 1);

   a_r13_neg_needs_pos: assert property (@(posedge clk) disable iff (!rst_n)
      neg_reg_en |-> pos_reg_en);

   a_r8_dis_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      dis_en |-> (!pos_reg_en && !neg_reg_en && !out_hiz));

   a_r8_dis_window: assert property (@(posedge clk) disable iff (!rst_n)
      dis_run <= RUN_W'(DIS_CYC));

   a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh[6] && rail_en) |=> state_oh[6]);

   a_r11_clear_on_regulate: assert property (@(posedge clk) disable iff (!rst_n)
      (state_oh[3] && !$past(state_oh[3])) |-> (fault_cause == 2'd0));

   a_r3_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_oh[6]) |-> (fault_cause == 2'd1));

   a_r2_neg_after_pos: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_oh[2]) |-> $past(state_oh[1]));

endmodule

bind bias_seq_ctrl bias_seq_chk #(.DIS_CYC(DIS_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .pos_reg_en(pos_reg_en),
   .neg_reg_en(neg_reg_en), .dis_en(dis_en), .out_hiz(out_hiz),
   .state_oh(state_oh), .fault_cause(fault_cause)
);

// File: tb/sim_bias_seq_ctrl.sv
`timescale 1ns/1ps
module sim_bias_seq_ctrl;

   localparam int SCP = 4, DIS = 6, PUP = 5, PTO = 9, NTO = 7;

   logic clk = 1'b0, rst_n = 1'b0;
   logic rail_en = 0, dis_opt = 0, uv_flag = 0, ot_flag = 0, ot_clr_flag = 0;
   logic short_flag = 0, pos_good = 0, neg_good = 0;
   logic pos_reg_en, neg_reg_en, dis_en, out_hiz;
   logic [6:0] state_oh;
   logic [1:0] fault_cause;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bias_seq_ctrl #(.SYNC_STAGES(2), .SCP_CYC(SCP), .POS_UP_CYC(PUP),
      .POS_TMO_CYC(PTO), .NEG_TMO_CYC(NTO), .DIS_CYC(DIS)) u0 (
      .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .dis_opt(dis_opt),
      .uv_flag(uv_flag), .ot_flag(ot_flag), .ot_clr_flag(ot_clr_flag),
      .short_flag(short_flag), .pos_good(pos_good), .neg_good(neg_good),
      .pos_reg_en(pos_reg_en), .neg_reg_en(neg_reg_en), .dis_en(dis_en),
      .out_hiz(out_hiz), .state_oh(state_oh), .fault_cause(fault_cause));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_bit(input int b, input int lim, output int found);
      found = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (state_oh[b]) begin found = 1; break; end
      end
   endtask

   task automatic bring_up;
      int f;
      rail_en = 1; pos_good = 1; neg_good = 1;
      wait_bit(3, 40, f);
      chk("R2 reach REGULATE", f, 1);
      chk("R11 cause cleared in REGULATE", fault_cause, 0);
   endtask

   task automatic power_down;
      dis_opt = 0; rail_en = 0;
      tick(3);
   endtask

   initial begin
      int n, f;
      tick(3);
      chk("R1 state in reset", state_oh, 7'b0000001);
      chk("R1 hiz in reset", out_hiz, 1);
      rst_n = 1;
      tick(3);
      chk("R1 state after reset", state_oh, 7'b0000001);
      chk("R1 enables low", {pos_reg_en, neg_reg_en, dis_en}, 0);
      chk("R1 cause", fault_cause, 0);

      // R2: exact START_POS dwell, then START_NEG waiting on neg_good
      pos_good = 1; tick(3);
      rail_en = 1;
      n = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (state_oh[1]) begin
            n++;
            if (neg_reg_en || !pos_reg_en) chk("R13 pos only in START_POS", 0, 1);
         end
         if (state_oh[2]) break;
      end
      chk("R2 START_POS dwell", n, PUP);
      tick(2);
      chk("R2 START_NEG holds", state_oh, 7'b0000100);
      chk("R2 both regulators", {pos_reg_en, neg_reg_en}, 3);
      bring_up();

      // R10/R9: power-off without discharge
      rail_en = 0;
      @(negedge clk);
      chk("R9 direct to HIZ", state_oh, 7'b0100000);
      chk("R10 cause unchanged", fault_cause, 0);
      chk("R9 no discharge", dis_en, 0);

      // R4: sweep short pulse length
      for (int len = 1; len <= SCP + 1; len++) begin
         bring_up();
         short_flag = 1; tick(len); short_flag = 0;
         tick(6);
         if (len >= SCP) begin
            chk("R4 qualified short latches", state_oh, 7'b1000000);
            chk("R11 short cause", fault_cause, 1);
            tick(10);
            chk("R5 latched holds with enable high", state_oh, 7'b1000000);
            rail_en = 0; @(negedge clk);
            chk("R5 release to HIZ", state_oh, 7'b0100000);
         end else begin
            chk("R4 short pulse ignored", state_oh, 7'b0001000);
            power_down();
         end
      end
      bring_up();
      short_flag = 1; tick(SCP - 1); short_flag = 0; tick(1);
      short_flag = 1; tick(SCP - 1); short_flag = 0; tick(6);
      chk("R4 gap restarts count", state_oh, 7'b0001000);

      // R8: power-off discharge window
      dis_opt = 1; rail_en = 0; n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (dis_en) n++;
         if (state_oh[5]) break;
      end
      chk("R8 power-off discharge length", n, DIS);
      chk("R8 ends in HIZ", state_oh, 7'b0100000);

      // R6/R8: thermal fault with discharge, UV pulse inside the window
      bring_up();
      dis_opt = 1; ot_flag = 1; n = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (dis_en) begin
            n++;
            if (n == 2) uv_flag = 1;
            if (n == 4) uv_flag = 0;
         end
         if (state_oh[5] || state_oh[6]) break;
      end
      chk("R8 window not restarted", n, DIS);
      chk("R6 thermal ends in HIZ", state_oh, 7'b0100000);
      chk("R8 cause not altered", fault_cause, 2);
      ot_flag = 0; tick(10);
      chk("R6 no restart before cleared", state_oh, 7'b0100000);
      ot_clr_flag = 1;
      wait_bit(3, 40, f);
      chk("R6 auto restart", f, 1);
      ot_clr_flag = 0;

      // R7: undervoltage
      dis_opt = 0; uv_flag = 1; tick(4);
      chk("R7 UV shutdown", state_oh, 7'b0100000);
      chk("R11 UV cause", fault_cause, 3);
      tick(10);
      chk("R7 held while UV", state_oh, 7'b0100000);
      uv_flag = 0;
      wait_bit(3, 40, f);
      chk("R7 auto restart", f, 1);

      // R11: priority UV over thermal
      uv_flag = 1; ot_flag = 1; tick(4);
      chk("R11 priority", fault_cause, 3);
      uv_flag = 0; ot_flag = 0; ot_clr_flag = 1;
      wait_bit(3, 40, f);
      chk("R11 restart after both clear", f, 1);
      ot_clr_flag = 0;

      // R3: positive start timeout
      power_down();
      pos_good = 0; tick(3);
      rail_en = 1; n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (state_oh[1]) n++;
         if (state_oh[6]) break;
      end
      chk("R3 positive timeout length", n, PTO);
      chk("R3 positive timeout latches", state_oh, 7'b1000000);
      chk("R3 cause short", fault_cause, 1);
      power_down();

      // R3: negative start timeout
      pos_good = 1; neg_good = 0; tick(3);
      rail_en = 1; n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (state_oh[2]) n++;
         if (state_oh[6]) break;
      end
      chk("R3 negative timeout length", n, NTO);
      chk("R3 negative timeout latches", state_oh, 7'b1000000);
      power_down();
      chk("R12 final HIZ code", state_oh, 7'b0100000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule